// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block holds a set of one-bit mutual-exclusion flags that several processors share through one 32-bit register port. A processor claims a lock by reading that lock's word. If the read returns 0, the lock was free and now belongs to the reader. If it returns 1, another owner holds it and nothing changes. The owner frees the lock by writing 0 to the same word.

Test and set take place in one clock on the single port, so no two readers can both be granted the same lock. A read-only status word at offset zero carries a coded lock count, so software can find the bank size without being told. The lock count is a synthesis parameter restricted to 32, 64, 128 or 256.

Top module: `hwlock_bank`

## Requirements
- R1: A read of byte offset 0x000 returns a status word whose bits 31:28 hold the code n = log2(NUM_LOCKS) - 4, with every other bit 0. That gives 1 for 32 locks (0x10000000), 2 for 64, 3 for 128 and 4 for 256.
- R2: Lock i is the 32-bit word at byte offset 0x100 + 4*i. Address bits 1:0 are ignored.
- R3: A read of a free lock returns 0, and the lock is held from the next cycle on.
- R4: A read of a held lock returns 1 and leaves every lock unchanged.
- R5: Two back-to-back reads of a free lock return 0 and then 1.
- R6: Writing 0 to a lock word frees that lock and no other.
- R7: A nonzero write to a lock word is ignored. Any write to the status word is ignored.
- R8: Reset, active low and asynchronous, frees every lock and clears the read data to 0.
- R9: A read of an unmapped offset, or of a lock index at or beyond NUM_LOCKS, returns 0 and changes no lock.
- R10: Read data is registered. It appears in the cycle after the read enable and is 0 in any cycle that does not follow a read.
- R11: When read and write enables are both high, the read is performed and the write is ignored.
- R12: At most one lock changes state per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_rd | input | 1 | Read enable; a read of a lock word acquires it if free |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data; 0 to a lock word releases it |
| bus_rdata | output | 32 | Registered read data |

## Verification
Directed patterns cover several cases: back-to-back reads of one lock, which separate a one-cycle test-and-set from a delayed update; a release followed by reads of two locks, which shows the release is confined to one index; and nonzero and status writes, which must leave state alone. Reads just past the configured count and in the gap below the lock region separate correct range decoding from index aliasing. A second instance with 256 locks shows how the status code and the top index scale with the parameter. A long pseudo-random mix of reads, zero and nonzero writes, and overlapping enables is compared every clock against a behavioural model. That mix exposes any wrong-index or wrong-priority update.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned LOCK_BASE_WORD = 'h40;
  localparam int unsigned CODE_LSB       = 28;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_LOCK   = 2'd2
  } sel_e;

  function automatic logic [3:0] count_code(input int unsigned n);
    case (n)
      32:      return 4'd1;
      64:      return 4'd2;
      128:     return 4'd3;
      256:     return 4'd4;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS),
  localparam int unsigned WORD_W   = ADDR_W - 2
) (
  input  logic [WORD_W-1:0] word_addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx,
  output logic              acq_en,
  output logic              rel_en
);
  logic [WORD_W-1:0] lock_off;
  logic              in_lock;
  logic [WORD_W-1:0] unused_off_hi;

  always_comb begin
    lock_off = word_addr - WORD_W'(LOCK_BASE_WORD);
    in_lock  = (word_addr >= WORD_W'(LOCK_BASE_WORD)) &&
               (lock_off < WORD_W'(NUM_LOCKS));
    idx      = lock_off[IDX_W-1:0];
    if (word_addr == '0)  sel = SEL_STATUS;
    else if (in_lock)     sel = SEL_LOCK;
    else                  sel = SEL_NONE;
    acq_en = rd && in_lock;
    rel_en = wr && !rd && in_lock && (wdata == '0);
  end

  assign unused_off_hi = lock_off >> IDX_W;
endmodule

// File: rtl/hwlock_flags.sv
module hwlock_flags #(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_en,
  input  logic                 rel_en,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LOCKS-1:0] lock_vec
);
  logic [NUM_LOCKS-1:0] lock_d;
  logic [NUM_LOCKS-1:0] lock_en;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    always_comb begin
      lock_en[g] = (acq_en || rel_en) && (idx == IDX_W'(g));
      lock_d[g]  = acq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lock_vec[g] <= 1'b0;
      else if (lock_en[g]) lock_vec[g] <= lock_d[g];
    end
  end

  // R3
  acquire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_en |=> lock_vec[$past(idx)]);
  // R6
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !acq_en) |=> !lock_vec[$past(idx)]);
endmodule

// File: rtl/hwlock_readback.sv
module hwlock_readback
  import hwlock_pkg::*;
#(
  parameter logic [DATA_W-1:0] STATUS_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  sel_e              sel,
  input  logic              taken,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      case (sel)
        SEL_STATUS: rdata_d = STATUS_WORD;
        SEL_LOCK:   rdata_d = {{(DATA_W-1){1'b0}}, taken};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned IDX_W  = $clog2(NUM_LOCKS);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [3:0]  CODE   = count_code(NUM_LOCKS);
  localparam logic [DATA_W-1:0] STATUS_WORD = DATA_W'(CODE) << CODE_LSB;

  if (CODE == 4'd0) begin : g_bad_count
    $error("hwlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
  end

  sel_e                 sel;
  logic [IDX_W-1:0]     idx;
  logic                 acq_en;
  logic                 rel_en;
  logic [NUM_LOCKS-1:0] lock_vec;
  logic                 taken;
  logic [1:0]           unused_low_bits;

  assign unused_low_bits = bus_addr[1:0];
  assign taken           = lock_vec[idx];

  hwlock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_decode (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .sel       (sel),
    .idx       (idx),
    .acq_en    (acq_en),
    .rel_en    (rel_en)
  );

  hwlock_flags #(.NUM_LOCKS(NUM_LOCKS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_en   (acq_en),
    .rel_en   (rel_en),
    .idx      (idx),
    .lock_vec (lock_vec)
  );

  hwlock_readback #(.STATUS_WORD(STATUS_WORD)) u_readback (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (bus_rd),
    .sel   (sel),
    .taken (taken),
    .rdata (bus_rdata)
  );

  // R1
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[ADDR_W-1:2] == '0) |=> (bus_rdata == STATUS_WORD));
  // R4
  held_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_LOCK && taken) |=> ($stable(lock_vec) && bus_rdata == 32'd1));
  // R7
  nonzero_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_wdata != '0) |=> $stable(lock_vec));
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0 && $stable(lock_vec)));
  // R12
  single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_vec ^ $past(lock_vec)) <= 1);
endmodule

// File: tb/hwlock_bank_bench.sv
module hwlock_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 32;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] wide_rdata;

  int checks;
  int errors;
  bit mlock [NL];
  logic [31:0] exp_rdata;
  string tag;

  hwlock_bank #(.NUM_LOCKS(NL)) u_hwlock_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  hwlock_bank #(.NUM_LOCKS(256)) u_hwlock_bank_wide (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(wide_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: lock flags in a bit array, expected read data per cycle.
  always @(posedge clk or negedge rst_n) begin
    int w;
    if (!rst_n) begin
      foreach (mlock[i]) mlock[i] = 1'b0;
      exp_rdata = 32'd0;
      tag = "R8";
    end else begin
      w = int'(bus_addr) / 4;
      exp_rdata = 32'd0;
      tag = "R10";
      if (bus_rd) begin
        if (w == 0) begin
          exp_rdata = 32'h1000_0000; tag = "R1";
        end else if (w >= 64 && w < 64 + NL) begin
          exp_rdata = {31'd0, mlock[w-64]};
          tag = mlock[w-64] ? "R4" : "R3";
          mlock[w-64] = 1'b1;
        end else begin
          tag = "R9";
        end
      end else if (bus_wr && w >= 64 && w < 64 + NL && bus_wdata == 32'd0) begin
        mlock[w-64] = 1'b0; tag = "R6";
      end else if (bus_wr) begin
        tag = "R7";
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string req);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check(bus_rdata, exp_rdata, tag);
  end

  task automatic op(input logic rd, input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'd0, "R8 rdata in reset");
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed;
    checks = 0; errors = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    op(1, 0, 12'h000, 0);  check(bus_rdata, 32'h1000_0000, "R1 status 32");
                           check(wide_rdata, 32'h4000_0000, "R1 status 256");
    op(0, 1, 12'h000, 32'hFFFF_FFFF);
    op(1, 0, 12'h000, 0);  check(bus_rdata, 32'h1000_0000, "R7 status write ignored");
    op(1, 0, 12'h100, 0);  check(bus_rdata, 32'd0, "R5 first read");
    op(1, 0, 12'h100, 0);  check(bus_rdata, 32'd1, "R5 second read");
    op(0, 0, 12'h100, 0);  check(bus_rdata, 32'd0, "R10 idle after read");
    op(1, 0, 12'h116, 0);  check(bus_rdata, 32'd0, "R2 lock 5 low bits");
    op(1, 0, 12'h114, 0);  check(bus_rdata, 32'd1, "R2 lock 5 held");
    op(0, 1, 12'h100, 32'd1);
    op(1, 0, 12'h100, 0);  check(bus_rdata, 32'd1, "R7 nonzero write ignored");
    op(0, 1, 12'h100, 32'd0);
    op(1, 0, 12'h114, 0);  check(bus_rdata, 32'd1, "R6 other lock kept");
    op(1, 0, 12'h100, 0);  check(bus_rdata, 32'd0, "R6 released");
    op(1, 0, 12'h080, 0);  check(bus_rdata, 32'd0, "R9 gap read");
    op(1, 0, 12'h180, 0);  check(bus_rdata, 32'd0, "R9 past count");
    op(1, 0, 12'h4FC, 0);  check(bus_rdata, 32'd0, "R9 far index");
                           check(wide_rdata, 32'd0, "R2 top lock of 256 acquired");
    op(1, 0, 12'h4FC, 0);  check(wide_rdata, 32'd1, "R4 top lock of 256 held");
    op(1, 0, 12'h17C, 0);  check(bus_rdata, 32'd0, "R3 last lock");
    op(1, 1, 12'h114, 32'd0); check(bus_rdata, 32'd1, "R11 read wins");
    op(1, 0, 12'h114, 0);  check(bus_rdata, 32'd1, "R11 write dropped");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = (seed[20:18] == 0) ? 12'(seed[11:2] << 2) : 12'(12'h100 + (seed[8:4] << 2));
      op(seed[24], seed[25], a, seed[26] ? 32'd0 : {31'd0, seed[27]});
    end

    do_reset();
    op(1, 0, 12'h114, 0);  check(bus_rdata, 32'd0, "R8 lock freed by reset");
    op(0, 0, 12'h000, 0);
    summary();
  end
endmodule